// File: doc/BRIEF.md
# Four-Mode Serial Port with Ninth-Bit Addressing

This block is a full-duplex serial port. It is driven over a two-address register port. One address holds a control/flag register. The other is the data address: a write to it starts a transmission, and a read returns a receive buffer that is kept apart from the transmitter.

It offers four line formats:
- Mode 0 is a clocked 8-bit shift, with data on the bidirectional receive pin and the shift clock on the transmit pin.
- Mode 1 is a 10-bit asynchronous frame.
- Modes 2 and 3 are 11-bit asynchronous frames that carry a ninth bit.

Mode 2 runs from an internal divider of the system clock. Modes 1 and 3 take a 16x oversampling tick from outside.

The receive path holds one finished byte while it shifts in the next one. A frame that finishes while the receive flag is still set is dropped. With multiprocessor filtering enabled, frames whose ninth bit is 0 do not raise the flag. This lets a node ignore data traffic until it sees an address frame.

The register port has no back-pressure: every access completes in the cycle it is presented. A data write during a transmission restarts the transmitter with the new byte, so software waits for the transmit flag before writing again. The interrupt output is the OR of the two flags.

Top module: `uart4_top`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, `txd` is high, `rxd_oe` is low and `irq` is low.
- R2: Control register layout: bits [1:0] mode, bit 2 receive enable, bit 3 multiprocessor filter, bit 4 transmit ninth bit, bit 5 received ninth bit, bit 6 TI, bit 7 RI. In mode 1 a data write (address 1) sends start 0, eight data bits LSB first, and stop 1, at 16 ticks per bit. On reception the stop bit is stored in bit 5.
- R3: In modes 2 and 3 the frame is start 0, eight data bits LSB first, the transmit ninth bit, and stop 1. The received ninth bit goes to bit 5 and the received stop bit is not checked.
- R4: A mode 2 bit lasts 64 clock cycles, or 32 when `fix_rate_fast` is high. Modes 1 and 3 count 16 pulses of `baud_tick` per bit.
- R5: In asynchronous modes TI rises as the stop bit starts. In every mode TI stays set until software writes it to 0.
- R6: RI is set once the last bit of a frame has been sampled, and the received byte is then readable at address 1. `irq` is high whenever RI or TI is set.
- R7: In modes 2 and 3 with bit 3 set, a frame whose ninth bit is 0 leaves RI, bit 5 and the buffer unchanged.
- R8: A frame that completes while RI is still set is discarded. The buffer keeps the earlier byte.
- R9: Each asynchronous bit is decided by a majority vote of oversample points 7, 8 and 9. A start bit that is not low at mid-bit is rejected, and the receiver returns to idle.
- R10: In mode 0 a data write drives the byte LSB first on `rxd_out` with `rxd_oe` high. Each bit lasts 12 clocks, with `txd` low for the first 6 and high for the last 6. TI is set after the eighth bit.
- R11: Mode 0 reception begins while receive enable is 1, RI is 0 and the transmitter is idle. `rxd_in` is sampled as `txd` rises, RI is set after eight bits, and no new reception starts while RI stays 1.
- R12: With receive enable at 0, an incoming asynchronous frame leaves RI and the buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register select: 0 control, 1 data |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| fix_rate_fast | input | 1 | Mode 2 rate select: 1 gives 32 clocks per bit |
| baud_tick | input | 1 | 16x oversampling tick for modes 1 and 3 |
| rxd_in | input | 1 | Receive line, also mode 0 data input |
| rxd_out | output | 1 | Mode 0 data output |
| rxd_oe | output | 1 | Output enable for `rxd_out` |
| txd | output | 1 | Transmit line, or shift clock in mode 0 |
| irq | output | 1 | Interrupt request, RI or TI |

## Verification
The hardest situations to reach are a frame completing while RI is still set, and a ninth-bit-0 frame under filtering. Neither shows anything at the outputs except the absence of a change. The bench loops `txd` back into `rxd_in` and sends a second frame without clearing RI. It also sends filtered frames and then reads back the buffer and flags to confirm they are untouched. The start-bit glitch is reached by driving `rxd_in` low for less than half a bit, then sending a clean frame to show the receiver recovered.

// File: rtl/uart4_pkg.sv
package uart4_pkg;
  typedef enum logic [1:0] {
    MD_SYNC   = 2'd0,
    MD_ASYNC8 = 2'd1,
    MD_FIX9   = 2'd2,
    MD_VAR9   = 2'd3
  } umode_e;

  typedef struct packed {
    logic   ri;
    logic   ti;
    logic   rx_b9;
    logic   tx_b9;
    logic   mp_en;
    logic   rx_en;
    umode_e mode;
  } ctrl_t;
endpackage

// File: rtl/uart4_tick.sv
module uart4_tick
  import uart4_pkg::*;
#(
  parameter int SLOW_DIV = 4,
  parameter int FAST_DIV = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  umode_e mode,
  input  logic   fast,
  input  logic   baud_tick,
  output logic   os_tick
);
  localparam int CW = $clog2(SLOW_DIV);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = fast ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (mode != MD_FIX9 || cnt == lim)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

  always_comb begin
    case (mode)
      MD_FIX9:           os_tick = (cnt == lim);
      MD_ASYNC8, MD_VAR9: os_tick = baud_tick;
      default:           os_tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/uart4_tx.sv
module uart4_tx
  import uart4_pkg::*;
#(
  parameter int OS       = 16,
  parameter int SYNC_DIV = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  umode_e     mode,
  input  logic       start,
  input  logic [7:0] din,
  input  logic       b9,
  input  logic       os_tick,
  output logic       ser,
  output logic       sclk,
  output logic       sdat,
  output logic       s_oe,
  output logic       busy,
  output logic       ti_set
);
  localparam int OSW = $clog2(OS);
  localparam int CW  = $clog2(SYNC_DIV);

  logic [10:0]    frame;
  logic [3:0]     idx;
  logic [OSW-1:0] osc;
  logic [CW-1:0]  cnt;
  logic [3:0]     last;
  logic           sync_md;

  assign sync_md = (mode == MD_SYNC);
  assign last    = (mode == MD_ASYNC8) ? 4'd9 : 4'd10;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      frame <= '1;
      idx   <= '0;
      osc   <= '0;
      cnt   <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
      osc  <= '0;
      cnt  <= '0;
      if (sync_md)
        frame <= {3'b111, din};
      else if (mode == MD_ASYNC8)
        frame <= {2'b11, din, 1'b0};
      else
        frame <= {1'b1, b9, din, 1'b0};
    end else if (busy) begin
      if (sync_md) begin
        if (cnt == CW'(SYNC_DIV - 1)) begin
          cnt <= '0;
          if (idx == 4'd7) busy <= 1'b0;
          else             idx  <= idx + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (os_tick) begin
        if (osc == OSW'(OS - 1)) begin
          osc <= '0;
          if (idx == last) busy <= 1'b0;
          else             idx  <= idx + 1'b1;
        end else begin
          osc <= osc + 1'b1;
        end
      end
    end
  end

  assign ti_set = sync_md
      ? (busy && cnt == CW'(SYNC_DIV - 1) && idx == 4'd7)
      : (busy && os_tick && osc == OSW'(OS - 1) && idx == last - 4'd1);

  assign ser  = (busy && !sync_md) ? frame[idx] : 1'b1;
  assign sclk = !(busy && sync_md && cnt < CW'(SYNC_DIV / 2));
  assign sdat = frame[idx[2:0]];
  assign s_oe = busy && sync_md;
endmodule

// File: rtl/uart4_rx.sv
module uart4_rx
  import uart4_pkg::*;
#(
  parameter int OS       = 16,
  parameter int SYNC_DIV = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  umode_e     mode,
  input  logic       rx_en,
  input  logic       ri,
  input  logic       tx_busy,
  input  logic       rxd,
  input  logic       os_tick,
  output logic       done,
  output logic [7:0] dout,
  output logic       b9,
  output logic       sclk
);
  localparam int OSW = $clog2(OS);
  localparam int CW  = $clog2(SYNC_DIV);
  localparam int MID = OS / 2;

  logic [1:0]     rs;
  logic           rxs;
  logic           busy;
  logic [3:0]     idx;
  logic [OSW-1:0] osc;
  logic [CW-1:0]  cnt;
  logic [7:0]     shreg;
  logic           s_a;
  logic           s_b;
  logic           maj;
  logic           sync_md;

  assign sync_md = (mode == MD_SYNC);
  assign rxs     = rs[1];
  assign maj     = (s_a & s_b) | (s_a & rxs) | (s_b & rxs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs    <= 2'b11;
      busy  <= 1'b0;
      idx   <= '0;
      osc   <= '0;
      cnt   <= '0;
      shreg <= '0;
      s_a   <= 1'b1;
      s_b   <= 1'b1;
    end else begin
      rs <= {rs[0], rxd};
      if (!busy) begin
        idx <= '0;
        osc <= '0;
        cnt <= '0;
        if (rx_en && sync_md && !ri && !tx_busy)
          busy <= 1'b1;
        else if (rx_en && !sync_md && !rxs)
          busy <= 1'b1;
      end else if (sync_md) begin
        if (cnt == CW'(SYNC_DIV / 2))
          shreg <= {rxs, shreg[7:1]};
        if (cnt == CW'(SYNC_DIV - 1)) begin
          cnt <= '0;
          if (idx == 4'd7) busy <= 1'b0;
          else             idx  <= idx + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (os_tick) begin
        if (osc == OSW'(MID - 1)) s_a <= rxs;
        if (osc == OSW'(MID))     s_b <= rxs;
        if (osc == OSW'(MID + 1)) begin
          if (idx == 4'd0) begin
            if (maj) busy <= 1'b0;
          end else if (idx == 4'd9) begin
            busy <= 1'b0;
          end else begin
            shreg <= {maj, shreg[7:1]};
          end
        end
        if (osc == OSW'(OS - 1)) begin
          osc <= '0;
          idx <= idx + 1'b1;
        end else begin
          osc <= osc + 1'b1;
        end
      end
    end
  end

  assign done = busy && (sync_md
      ? (cnt == CW'(SYNC_DIV - 1) && idx == 4'd7)
      : (os_tick && osc == OSW'(MID + 1) && idx == 4'd9));
  assign dout = shreg;
  assign b9   = maj;
  assign sclk = !(busy && sync_md && cnt < CW'(SYNC_DIV / 2));
endmodule

// File: rtl/uart4_top.sv
module uart4_top
  import uart4_pkg::*;
#(
  parameter int OS       = 16,
  parameter int SYNC_DIV = 12,
  parameter int SLOW_DIV = 4,
  parameter int FAST_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       fix_rate_fast,
  input  logic       baud_tick,
  input  logic       rxd_in,
  output logic       rxd_out,
  output logic       rxd_oe,
  output logic       txd,
  output logic       irq
);
  ctrl_t      ctrl_q;
  logic [7:0] ctrl_bits;
  logic [7:0] rx_buf;
  logic       os_tick;
  logic       wr_ctrl;
  logic       wr_data;
  logic       tx_ser;
  logic       tx_sclk;
  logic       tx_busy;
  logic       ti_set;
  logic       rx_done;
  logic [7:0] rx_byte;
  logic       rx_b9;
  logic       rx_sclk;
  logic       rx_accept;
  logic       filtered;

  assign ctrl_bits = ctrl_q;
  assign wr_ctrl   = bus_wr && !bus_sel;
  assign wr_data   = bus_wr && bus_sel;

  uart4_tick #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) tick_i (
    .clk(clk), .rst_n(rst_n), .mode(ctrl_q.mode), .fast(fix_rate_fast),
    .baud_tick(baud_tick), .os_tick(os_tick)
  );

  uart4_tx #(.OS(OS), .SYNC_DIV(SYNC_DIV)) tx_i (
    .clk(clk), .rst_n(rst_n), .mode(ctrl_q.mode), .start(wr_data),
    .din(bus_wdata), .b9(ctrl_q.tx_b9), .os_tick(os_tick), .ser(tx_ser),
    .sclk(tx_sclk), .sdat(rxd_out), .s_oe(rxd_oe), .busy(tx_busy),
    .ti_set(ti_set)
  );

  uart4_rx #(.OS(OS), .SYNC_DIV(SYNC_DIV)) rx_i (
    .clk(clk), .rst_n(rst_n), .mode(ctrl_q.mode), .rx_en(ctrl_q.rx_en),
    .ri(ctrl_q.ri), .tx_busy(tx_busy), .rxd(rxd_in), .os_tick(os_tick),
    .done(rx_done), .dout(rx_byte), .b9(rx_b9), .sclk(rx_sclk)
  );

  // Address filter: nine-bit modes with filtering on drop ninth-bit-0 frames
  assign filtered  = ctrl_q.mp_en && ctrl_q.mode[1] && !rx_b9;
  assign rx_accept = rx_done && !ctrl_q.ri && !filtered;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rx_buf <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata);
      if (ti_set)  ctrl_q.ti <= 1'b1;
      if (rx_accept) begin
        ctrl_q.ri <= 1'b1;
        rx_buf    <= rx_byte;
        if (ctrl_q.mode != MD_SYNC) ctrl_q.rx_b9 <= rx_b9;
      end
    end
  end

  assign txd       = (ctrl_q.mode == MD_SYNC) ? (tx_sclk & rx_sclk) : tx_ser;
  assign irq       = ctrl_q.ri | ctrl_q.ti;
  assign bus_rdata = bus_sel ? rx_buf : ctrl_bits;
endmodule

// File: rtl/uart4_chk.sv
module uart4_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctrl,
  input logic [7:0] rx_buf,
  input logic       bus_wr,
  input logic       bus_sel,
  input logic       txd,
  input logic       rxd_oe
);
  logic wr_ctrl;
  assign wr_ctrl = bus_wr && !bus_sel;

  assert_shift_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxd_oe) |-> $past(bus_wr && bus_sel));

  assert_ti_at_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctrl[6]) && ctrl[1:0] != 2'd0 && !$past(wr_ctrl)) |-> txd);

  assert_keep_buf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl[7]) |-> $stable(rx_buf));

  assert_addr_filter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctrl[7]) && !$past(wr_ctrl) && $past(ctrl[3]) && $past(ctrl[1])) |-> ctrl[5]);
endmodule

bind uart4_top uart4_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl_bits), .rx_buf(rx_buf),
  .bus_wr(bus_wr), .bus_sel(bus_sel), .txd(txd), .rxd_oe(rxd_oe)
);

// File: tb/uart4_top_tb_top.sv
`timescale 1ns/1ps
module uart4_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       fix_rate_fast = 1'b0;
  logic       baud_tick = 1'b0;
  logic       rxd_in;
  logic       rxd_out;
  logic       rxd_oe;
  logic       txd;
  logic       irq;
  logic       loop_en = 1'b1;
  logic       rxd_drv = 1'b1;
  int         total = 0;
  int         bad = 0;

  always #2.5 clk = ~clk;
  assign rxd_in = loop_en ? txd : rxd_drv;

  uart4_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fix_rate_fast(fix_rate_fast),
    .baud_tick(baud_tick), .rxd_in(rxd_in), .rxd_out(rxd_out), .rxd_oe(rxd_oe),
    .txd(txd), .irq(irq)
  );

  initial begin
    forever begin
      repeat (3) @(posedge clk);
      #1 baud_tick = 1'b1;
      @(posedge clk);
      #1 baud_tick = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    bus_sel = sel;
    #0.5 d = bus_rdata;
  endtask

  task automatic get_frame(input int nbits, input int per,
                           output logic [10:0] bits, output logic [10:0] tis);
    logic [7:0] c;
    bits = '0; tis = '0;
    if (txd) @(negedge txd);
    repeat (per / 2) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      bits[i] = txd;
      rd(1'b0, c);
      tis[i] = c[6];
      if (i < nbits - 1) repeat (per) @(negedge clk);
    end
  endtask

  task automatic drive_frame(input logic [10:0] bits, input int nbits, input int per);
    for (int i = 0; i < nbits; i++) begin
      rxd_drv = bits[i];
      repeat (per) @(negedge clk);
    end
    rxd_drv = 1'b1;
  endtask

  task automatic drive_sync(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      @(negedge txd);
      #1 rxd_drv = b[i];
    end
  endtask

  // {mode[1:0], mp, tx_b9, fast, data[7:0], exp_ri, exp_b9, pad}
  localparam logic [15:0] VEC [7] = '{
    {2'd1, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b1, 1'b1, 1'b0},
    {2'd1, 1'b0, 1'b0, 1'b0, 8'h3C, 1'b1, 1'b1, 1'b0},
    {2'd2, 1'b0, 1'b1, 1'b0, 8'h5A, 1'b1, 1'b1, 1'b0},
    {2'd2, 1'b0, 1'b0, 1'b1, 8'h81, 1'b1, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b0, 1'b0, 8'h77, 1'b0, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b1, 1'b0, 8'hC3, 1'b1, 1'b1, 1'b0},
    {2'd2, 1'b1, 1'b0, 1'b1, 8'h11, 1'b0, 1'b0, 1'b0}
  };

  initial begin
    logic [7:0]  c;
    logic [7:0]  d;
    logic [7:0]  last_buf;
    logic [10:0] bits;
    logic [10:0] tis;
    logic [10:0] exp;
    logic [10:0] mask;
    int          nb;
    int          per;
    int          n;
    realtime     t0;
    realtime     t1;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(1'b0, c);
    chk("R1 ctrl after reset", c, 8'h00);
    chk("R1 txd idle", txd, 1'b1);
    chk("R1 rxd_oe low", rxd_oe, 1'b0);
    chk("R1 irq low", irq, 1'b0);

    last_buf = 8'h00;
    loop_en = 1'b1;
    for (int v = 0; v < 7; v++) begin
      logic [1:0] md;
      logic mp, b9, fst, eri, eb9;
      logic [7:0] dat;
      {md, mp, b9, fst, dat, eri, eb9} = VEC[v][15:1];
      fix_rate_fast = fst;
      nb  = (md == 2'd1) ? 10 : 11;
      per = (md == 2'd2 && fst) ? 32 : 64;
      wr(1'b0, {3'b000, b9, mp, 1'b1, md});
      wr(1'b1, dat);
      get_frame(nb, per, bits, tis);
      exp = (md == 2'd1) ? {2'b01, dat, 1'b0} : {1'b1, b9, dat, 1'b0};
      mask = (md == 2'd1) ? 11'h3FF : 11'h7FF;
      chk($sformatf("R2 R3 R4 frame bits vec %0d", v), bits & mask, exp);
      chk($sformatf("R5 TI low before stop vec %0d", v), tis[nb-2], 1'b0);
      chk($sformatf("R5 TI set at stop vec %0d", v), tis[nb-1], 1'b1);
      repeat (per) @(negedge clk);
      rd(1'b0, c);
      chk($sformatf("R6 R7 RI vec %0d", v), c[7], eri);
      if (eri) begin
        chk($sformatf("R2 R3 rx ninth bit vec %0d", v), c[5], eb9);
        last_buf = dat;
      end else begin
        chk($sformatf("R7 ninth bit kept vec %0d", v), c[5], 1'b0);
      end
      rd(1'b1, d);
      chk($sformatf("R6 R7 buffer vec %0d", v), d, last_buf);
      chk($sformatf("R6 irq vec %0d", v), irq, 1'b1);
    end

    // R4: start bit length in mode 2
    for (int f = 0; f < 2; f++) begin
      fix_rate_fast = f[0];
      wr(1'b0, 8'h06);
      wr(1'b1, 8'h01);
      n = 1;
      while (!txd && n < 200) begin @(negedge clk); n++; end
      chk($sformatf("R4 start bit length fast=%0d in range", f),
          (n >= (f ? 28 : 58) && n <= (f ? 34 : 66)), 1'b1);
      repeat (12 * 64) @(negedge clk);
    end
    fix_rate_fast = 1'b0;

    // R8: second frame while RI set is lost
    wr(1'b0, 8'h05);
    wr(1'b1, 8'h12);
    get_frame(10, 64, bits, tis);
    repeat (64) @(negedge clk);
    wr(1'b1, 8'h34);
    get_frame(10, 64, bits, tis);
    repeat (64) @(negedge clk);
    rd(1'b1, d);
    chk("R8 buffer keeps first byte", d, 8'h12);
    rd(1'b0, c);
    chk("R8 RI still set", c[7], 1'b1);
    repeat (100) @(negedge clk);
    chk("R5 TI held", c[6], 1'b1);
    wr(1'b0, 8'h05);
    chk("R5 R6 irq clear after flags written 0", irq, 1'b0);

    // R9: short start glitch rejected, clean frame then accepted
    loop_en = 1'b0;
    rxd_drv = 1'b0;
    repeat (12) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (300) @(negedge clk);
    rd(1'b0, c);
    chk("R9 glitch gives no RI", c[7], 1'b0);
    drive_frame({2'b01, 8'h6B, 1'b0}, 10, 64);
    repeat (32) @(negedge clk);
    rd(1'b0, c);
    chk("R9 frame after glitch sets RI", c[7], 1'b1);
    rd(1'b1, d);
    chk("R9 frame after glitch data", d, 8'h6B);

    // R12: receiver disabled
    wr(1'b0, 8'h01);
    drive_frame({2'b01, 8'hE1, 1'b0}, 10, 64);
    repeat (32) @(negedge clk);
    rd(1'b0, c);
    chk("R12 no RI when disabled", c[7], 1'b0);
    rd(1'b1, d);
    chk("R12 buffer unchanged", d, 8'h6B);

    // R10: mode 0 transmit
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h96);
    d = '0; n = 0;
    t0 = 0; t1 = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge txd);
      if (i == 0) t0 = $realtime;
      if (i == 1) t1 = $realtime;
      #1 d[i] = rxd_out;
      if (rxd_oe) n++;
    end
    chk("R10 shifted byte LSB first", d, 8'h96);
    chk("R10 rxd_oe during shift", n, 8);
    chk("R10 bit period 12 clocks", int'(t1 - t0), 60);
    repeat (20) @(negedge clk);
    rd(1'b0, c);
    chk("R10 TI after eighth bit", c[6], 1'b1);
    chk("R10 rxd_oe released", rxd_oe, 1'b0);

    // R11: mode 0 receive
    fork
      drive_sync(8'hB4);
    join_none
    wr(1'b0, 8'h04);
    repeat (8 * 12 + 20) @(negedge clk);
    rd(1'b0, c);
    chk("R11 RI after eight bits", c[7], 1'b1);
    rd(1'b1, d);
    chk("R11 received byte", d, 8'hB4);
    n = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!txd) n++;
    end
    chk("R11 no restart while RI set", n, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule